// File: doc/BRIEF.md
# ADC Measurement Sequencer

This block paces an external 8-bit converter through a repeating measurement cycle. A cycle opens with a calibration conversion and then visits voltage channels 1, 2 and 3 in that order. It then closes with an end-of-cycle step, and the next cycle begins at once. Each channel has a 5-bit input-select register. The select code 5'h1F takes a channel out of the cycle. Before every conversion the sequencer presents the select code and waits a programmable settling time. It then raises a convert request and holds it until the converter answers with convert-done and a data byte.

Software works through a flat 8-bit register file with a write strobe and a combinational read port. A global run bit starts the sequencer. Every time this bit goes from 0 to 1, an activation wait of `ACT_CYCLES` clocks comes before the first conversion. The run bit is cleared by a software write, by the warm-reset input or by the idle-mode input. Each channel result is kept in its own data register, and each completed conversion sets a data-valid flag. An end-of-cycle flag marks a finished cycle. Each flag has a mask bit, and the single interrupt output is high while any flag and its mask bit are both set.

Top module: `adc_seq`

## Requirements
- R1: Every cycle issues its conversions in the order calibration (`convCal`=1, `convSel`=0), channel 1, channel 2, channel 3, and the end-of-cycle step comes after the last of them.
- R2: A channel whose select register (address 4+i for channel i+1, bits 4:0) holds 5'h1F gets no convert request, its data-valid flag is not set and its data register keeps its value.
- R3: `convReq` stays low for at least SETTLE+2 clocks before each request, where SETTLE is the value at address 3. The settling wait counts SETTLE+1 of these clocks.
- R4: When convert-done arrives, the byte on `convData` is stored in that channel's data register (address 8+i for channel i+1), and the channel's data-valid flag (status bit i+1) is set. `convReq` holds high until convert-done.
- R5: The end-of-cycle flag (status register, address 1, bit 0) is set after the last conversion of each cycle.
- R6: After the run bit (address 0, bit 0) goes from 0 to 1, no convert request appears for at least `ACT_CYCLES` clocks. This holds for every re-enable.
- R7: A write to a select register during a cycle takes effect only from the start of the next cycle.
- R8: `irq` is high exactly when some status bit and the matching mask bit (address 2, same bit position) are both 1. Once high, it stays high until software writes the status or mask register, or a warm reset occurs.
- R9: Clearing the run bit by a software write, asserting `warmRst` or asserting `idleReq` clears the run bit and stops the sequencer. `convReq` is low from the following clock on.
- R10: Power-up reset (`rstN` low) and warm reset both clear the run bit, all mask bits, the end-of-cycle flag and all data-valid flags.
- R11: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If hardware sets a flag in the same clock as a clear, the flag ends up set.
- R12: While the run bit stays set, a new cycle with its calibration conversion follows each end-of-cycle step without any software action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous power-up reset, active low |
| warmRst | input | 1 | Synchronous warm reset, active high |
| idleReq | input | 1 | Idle-mode request; clears the run bit |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 4 | Register address for reads and writes |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data (combinational) |
| convReq | output | 1 | Convert request, held until convert-done |
| convCal | output | 1 | Current conversion is the calibration step |
| convSel | output | 5 | Input select for the current step |
| convDone | input | 1 | Converter finished; `convData` is valid |
| convData | input | 8 | Converter result |
| irq | output | 1 | Level-high interrupt |

## Verification
The bench uses random channel mixes with some channels switched off. A design that did not skip correctly would request the 5'h1F code, or set flags and overwrite data for a channel that is switched off. One test changes a select register during the calibration step. A design that reads the registers live instead of latching them at cycle start would show the new code one cycle too early. A data-valid clear is timed onto the same clock as a hardware set; if the clear wins, the flag reads back 0. The bench also measures the quiet time after each enable and between requests. This exposes a shortened activation or settling wait, and a sequencer that keeps running after an idle request or a warm reset.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int REG_W    = 8;
  localparam int SEL_W    = 5;
  localparam int CH_IDX_W = 2;
  localparam logic [SEL_W-1:0] SEL_OFF = 5'h1F;

  localparam logic [3:0] ADDR_CTRL   = 4'd0;
  localparam logic [3:0] ADDR_STAT   = 4'd1;
  localparam logic [3:0] ADDR_MASK   = 4'd2;
  localparam logic [3:0] ADDR_SETTLE = 4'd3;
  localparam logic [3:0] ADDR_SEL0   = 4'd4;
  localparam logic [3:0] ADDR_DATA0  = 4'd8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ACT, ST_START, ST_NEXT, ST_SETTLE, ST_CONV, ST_EOC
  } seqState_t;

  typedef struct packed {
    logic                loadSnap;
    logic                store;
    logic [CH_IDX_W-1:0] storeIdx;
    logic                setEoc;
  } seqStrobe_t;
endpackage

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NCH        = 3,
  parameter int DLY_W      = 8,
  parameter int ACT_CYCLES = 20000
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      warmRst,
  input  logic                      enable,
  input  logic [NCH-1:0][SEL_W-1:0] selSnap,
  input  logic [DLY_W-1:0]          settleVal,
  input  logic                      convDone,
  output logic                      convReq,
  output logic                      convCal,
  output logic [SEL_W-1:0]          convSel,
  output seqStrobe_t                strobe
);
  localparam int STEP_W = $clog2(NCH + 2);
  localparam int ACT_W  = $clog2(ACT_CYCLES + 1);
  localparam int CNT_W  = (ACT_W > DLY_W) ? ACT_W : DLY_W;
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NCH + 1);

  seqState_t           stateQ;
  logic [STEP_W-1:0]   stepQ;
  logic [CNT_W-1:0]    cntQ;
  logic [CH_IDX_W-1:0] chIdx;

  assign chIdx = CH_IDX_W'(stepQ - STEP_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      stepQ  <= '0;
      cntQ   <= '0;
    end else if (warmRst || !enable) begin
      stateQ <= ST_IDLE;
      stepQ  <= '0;
    end else begin
      unique case (stateQ)
        ST_IDLE: begin
          stateQ <= ST_ACT;
          cntQ   <= CNT_W'(ACT_CYCLES - 1);
        end
        ST_ACT: begin
          if (cntQ == '0) stateQ <= ST_START;
          else            cntQ   <= cntQ - CNT_W'(1);
        end
        ST_START: begin
          stepQ  <= '0;
          stateQ <= ST_NEXT;
        end
        ST_NEXT: begin
          if (stepQ == LAST_STEP) begin
            stateQ <= ST_EOC;
          end else if (stepQ != '0 && selSnap[chIdx] == SEL_OFF) begin
            stepQ <= stepQ + STEP_W'(1);
          end else begin
            cntQ   <= CNT_W'(settleVal);
            stateQ <= ST_SETTLE;
          end
        end
        ST_SETTLE: begin
          if (cntQ == '0) stateQ <= ST_CONV;
          else            cntQ   <= cntQ - CNT_W'(1);
        end
        ST_CONV: begin
          if (convDone) begin
            stepQ  <= stepQ + STEP_W'(1);
            stateQ <= ST_NEXT;
          end
        end
        ST_EOC:  stateQ <= ST_START;
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.loadSnap = (stateQ == ST_START);
    strobe.store    = (stateQ == ST_CONV) && convDone && (stepQ != '0);
    strobe.storeIdx = chIdx;
    strobe.setEoc   = (stateQ == ST_EOC);
  end

  assign convReq = (stateQ == ST_CONV);
  assign convCal = (stepQ == '0);
  assign convSel = (stepQ == '0) ? '0 : selSnap[chIdx];
endmodule

// File: rtl/adc_seq_dp.sv
module adc_seq_dp
  import adc_seq_pkg::*;
#(
  parameter int NCH   = 3,
  parameter int DLY_W = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      warmRst,
  input  logic                      idleReq,
  input  logic                      regWr,
  input  logic [3:0]                regAddr,
  input  logic [REG_W-1:0]          regWrData,
  output logic [REG_W-1:0]          regRdData,
  input  seqStrobe_t                strobe,
  input  logic [REG_W-1:0]          convData,
  output logic                      enableQ,
  output logic [NCH-1:0][SEL_W-1:0] selSnap,
  output logic [DLY_W-1:0]          settleVal,
  output logic                      irq
);
  localparam int NFLAG = NCH + 1;

  logic [NFLAG-1:0]            maskQ, flagQ, setVec, clrVec;
  logic [NCH-1:0][SEL_W-1:0]   selQ;
  logic [NCH-1:0][REG_W-1:0]   dataQ;
  logic [DLY_W-1:0]            settleQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              enableQ <= 1'b0;
    else if (warmRst || idleReq)            enableQ <= 1'b0;
    else if (regWr && regAddr == ADDR_CTRL) enableQ <= regWrData[0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              maskQ <= '0;
    else if (warmRst)                       maskQ <= '0;
    else if (regWr && regAddr == ADDR_MASK) maskQ <= regWrData[NFLAG-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                settleQ <= '0;
    else if (regWr && regAddr == ADDR_SETTLE) settleQ <= regWrData[DLY_W-1:0];
  end

  assign setVec[0] = strobe.setEoc;
  assign clrVec    = (regWr && regAddr == ADDR_STAT) ? regWrData[NFLAG-1:0] : '0;

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    assign setVec[i+1] = strobe.store && (strobe.storeIdx == CH_IDX_W'(i));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                      selQ[i] <= SEL_OFF;
      else if (regWr && regAddr == ADDR_SEL0 + 4'(i)) selQ[i] <= regWrData[SEL_W-1:0];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              selSnap[i] <= SEL_OFF;
      else if (strobe.loadSnap) selSnap[i] <= selQ[i];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          dataQ[i] <= '0;
      else if (setVec[i+1]) dataQ[i] <= convData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        flagQ <= '0;
    else if (warmRst) flagQ <= '0;
    else              flagQ <= (flagQ & ~clrVec) | setVec;
  end

  assign irq       = |(flagQ & maskQ);
  assign settleVal = settleQ;

  always_comb begin
    regRdData = '0;
    unique case (regAddr)
      ADDR_CTRL:   regRdData[0]         = enableQ;
      ADDR_STAT:   regRdData[NFLAG-1:0] = flagQ;
      ADDR_MASK:   regRdData[NFLAG-1:0] = maskQ;
      ADDR_SETTLE: regRdData[DLY_W-1:0] = settleQ;
      default: begin
        for (int i = 0; i < NCH; i++) begin
          if (regAddr == ADDR_SEL0 + 4'(i))  regRdData[SEL_W-1:0] = selQ[i];
          if (regAddr == ADDR_DATA0 + 4'(i)) regRdData            = dataQ[i];
        end
      end
    endcase
  end
endmodule

// File: rtl/adc_seq.sv
module adc_seq
  import adc_seq_pkg::*;
#(
  parameter int NCH        = 3,
  parameter int DLY_W      = 8,
  parameter int ACT_CYCLES = 20000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             warmRst,
  input  logic             idleReq,
  input  logic             regWr,
  input  logic [3:0]       regAddr,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  output logic             convReq,
  output logic             convCal,
  output logic [SEL_W-1:0] convSel,
  input  logic             convDone,
  input  logic [REG_W-1:0] convData,
  output logic             irq
);
  seqStrobe_t                strobe;
  logic                      enableQ;
  logic [NCH-1:0][SEL_W-1:0] selSnap;
  logic [DLY_W-1:0]          settleVal;

  adc_seq_ctrl #(.NCH(NCH), .DLY_W(DLY_W), .ACT_CYCLES(ACT_CYCLES)) uCtrl (
    .clk(clk), .rstN(rstN), .warmRst(warmRst), .enable(enableQ),
    .selSnap(selSnap), .settleVal(settleVal), .convDone(convDone),
    .convReq(convReq), .convCal(convCal), .convSel(convSel), .strobe(strobe)
  );

  adc_seq_dp #(.NCH(NCH), .DLY_W(DLY_W)) uDp (
    .clk(clk), .rstN(rstN), .warmRst(warmRst), .idleReq(idleReq),
    .regWr(regWr), .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .strobe(strobe), .convData(convData), .enableQ(enableQ), .selSnap(selSnap),
    .settleVal(settleVal), .irq(irq)
  );
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk
  import adc_seq_pkg::*;
#(
  parameter int ACT_CYCLES = 20000
) (
  input logic             clk,
  input logic             rstN,
  input logic             warmRst,
  input logic             enableQ,
  input logic             regWr,
  input logic [3:0]       regAddr,
  input logic             convReq,
  input logic             convCal,
  input logic [SEL_W-1:0] convSel,
  input logic             convDone,
  input logic             irq
);
  localparam int AW = $clog2(ACT_CYCLES + 1) + 1;
  logic [AW-1:0] actCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            actCnt <= '0;
    else if (!enableQ)                    actCnt <= '0;
    else if (actCnt < AW'(ACT_CYCLES))    actCnt <= actCnt + AW'(1);
  end

  assert_skip_off_R2: assert property (@(posedge clk) disable iff (!rstN)
    convReq && !convCal |-> convSel != SEL_OFF);

  assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    convReq && !convDone && enableQ && !warmRst |=> convReq);

  assert_act_wait_R6: assert property (@(posedge clk) disable iff (!rstN)
    convReq |-> actCnt >= AW'(ACT_CYCLES));

  assert_irq_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    irq && !warmRst && !(regWr && (regAddr == ADDR_STAT || regAddr == ADDR_MASK)) |=> irq);

  assert_halt_R9: assert property (@(posedge clk) disable iff (!rstN)
    !enableQ |=> !convReq);
endmodule

bind adc_seq adc_seq_chk #(.ACT_CYCLES(ACT_CYCLES)) uChk (
  .clk(clk), .rstN(rstN), .warmRst(warmRst), .enableQ(enableQ),
  .regWr(regWr), .regAddr(regAddr), .convReq(convReq), .convCal(convCal),
  .convSel(convSel), .convDone(convDone), .irq(irq)
);

// File: tb/sim_adc_seq.sv
`timescale 1ns/1ps
module sim_adc_seq;
  localparam int ACT = 40;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       warmRst = 1'b0, idleReq = 1'b0;
  logic       regWr = 1'b0;
  logic [3:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       convReq, convCal;
  logic [4:0] convSel;
  logic       convDone = 1'b0;
  logic [7:0] convData = '0;
  logic       irq;

  adc_seq #(.NCH(3), .DLY_W(8), .ACT_CYCLES(ACT)) u0 (
    .clk(clk), .rstN(rstN), .warmRst(warmRst), .idleReq(idleReq),
    .regWr(regWr), .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .convReq(convReq), .convCal(convCal), .convSel(convSel),
    .convDone(convDone), .convData(convData), .irq(irq)
  );

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // converter model state
  logic       logCal [0:63];
  logic [4:0] logSel [0:63];
  int         logN = 0, firstReqCyc = 0;
  logic [7:0] dataKey = 8'h00;
  bit         collideArm = 0;
  logic [4:0] collideSel = '0;
  int         lowCnt = 0, minGap = 1000;

  function automatic logic [7:0] dataOf(logic [4:0] s, logic [7:0] k);
    return (8'(s) * 8'd37) ^ k;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    finishRun();
  end

  // converter responder
  initial begin
    forever begin
      @(negedge clk);
      if (convReq && !convDone) begin
        bit collide;
        int lat;
        collide = 0;
        if (logN == 0) firstReqCyc = cyc;
        if (logN < 64) begin logCal[logN] = convCal; logSel[logN] = convSel; end
        logN++;
        lat = int'($urandom % 4);
        repeat (lat) @(negedge clk);
        convDone = 1'b1;
        convData = convCal ? 8'($urandom) : dataOf(convSel, dataKey);
        if (collideArm && !convCal && convSel == collideSel) begin
          regWr = 1'b1; regAddr = 4'd1; regWrData = 8'h02; collide = 1;
        end
        @(negedge clk);
        convDone = 1'b0;
        if (collide) begin regWr = 1'b0; collideArm = 0; end
      end
    end
  end

  // quiet-time monitor before each request
  initial begin
    forever begin
      @(negedge clk);
      if (!convReq) lowCnt++;
      else if (lowCnt > 0) begin
        if (lowCnt < minGap) minGap = lowCnt;
        lowCnt = 0;
      end
    end
  end

  task automatic wrReg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rdReg(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic waitEoc(output bit ok);
    logic [7:0] d;
    ok = 0;
    for (int i = 0; i < 3000 && !ok; i++) begin
      rdReg(4'd1, d);
      if (d[0]) ok = 1;
    end
  endtask

  task automatic waitLog(input int n, output bit ok);
    ok = 0;
    for (int i = 0; i < 3000 && !ok; i++) begin
      @(negedge clk);
      if (logN >= n) ok = 1;
    end
  endtask

  logic [4:0] cfgSel [0:2];
  logic [7:0] mdlData [0:2];

  initial begin
    logic [7:0] d, expStat, msk, dly;
    int enCyc, k, highs;
    bit ok;
    logic       expCal [0:6];
    logic [4:0] expSel [0:6];

    void'($urandom(32'd2024));
    for (int c = 0; c < 3; c++) mdlData[c] = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // reset state
    rdReg(4'd0, d); chk(d == 8'h00, "R10 run bit after reset", d, 0);
    rdReg(4'd1, d); chk(d == 8'h00, "R10 flags after reset", d, 0);
    rdReg(4'd2, d); chk(d == 8'h00, "R10 masks after reset", d, 0);
    chk(irq == 1'b0 && convReq == 1'b0, "R8 irq/req after reset", {irq, convReq}, 0);

    // random channel mixes
    for (int it = 0; it < 8; it++) begin
      wrReg(4'd0, 8'h00);
      repeat (6) @(negedge clk);
      wrReg(4'd1, 8'hFF);
      for (int c = 0; c < 3; c++) begin
        cfgSel[c] = ($urandom % 3 == 0) ? 5'h1F : 5'($urandom % 31);
        wrReg(4'(4 + c), {3'b000, cfgSel[c]});
      end
      dly = 8'($urandom % 8);
      wrReg(4'd3, dly);
      msk = 8'($urandom % 16);
      wrReg(4'd2, msk);
      dataKey = 8'($urandom);
      logN = 0; minGap = 1000;
      wrReg(4'd0, 8'h01);
      enCyc = cyc;
      waitEoc(ok);
      chk(ok, "R5 end-of-cycle flag seen", ok, 1);
      wrReg(4'd0, 8'h00);
      chk(firstReqCyc - enCyc >= ACT, "R6 activation wait", firstReqCyc - enCyc, ACT);
      chk(logCal[0] == 1'b1, "R1 calibration first", logCal[0], 1);
      k = 1;
      expStat = 8'h01;
      for (int c = 0; c < 3; c++) begin
        if (cfgSel[c] != 5'h1F) begin
          chk(logCal[k] == 1'b0 && logSel[k] == cfgSel[c], "R1 channel order", logSel[k], cfgSel[c]);
          k++;
          mdlData[c] = dataOf(cfgSel[c], dataKey);
          expStat[c+1] = 1'b1;
        end
      end
      chk(minGap >= int'(dly) + 2, "R3 settling quiet time", minGap, int'(dly) + 2);
      rdReg(4'd1, d); chk(d == expStat, "R4 R2 data-valid flags", d, expStat);
      for (int c = 0; c < 3; c++) begin
        rdReg(4'(8 + c), d);
        chk(d == mdlData[c], "R4 R2 channel data", d, mdlData[c]);
      end
      chk(irq == |(expStat & msk), "R8 irq level", irq, |(expStat & msk));
      wrReg(4'd1, 8'h01);
      rdReg(4'd1, d); chk(d == (expStat & 8'hFE), "R11 write-one clear", d, expStat & 8'hFE);
      chk(irq == |(expStat & 8'hFE & msk), "R8 irq after clear", irq, |(expStat & 8'hFE & msk));
    end

    // select change mid-cycle, back-to-back cycles
    wrReg(4'd0, 8'h00);
    repeat (6) @(negedge clk);
    wrReg(4'd4, 8'd5); wrReg(4'd5, 8'h1F); wrReg(4'd6, 8'd7); wrReg(4'd3, 8'd6);
    logN = 0;
    wrReg(4'd0, 8'h01);
    waitLog(1, ok);
    wrReg(4'd5, 8'd9);
    waitLog(7, ok);
    chk(ok, "R12 second cycle started", logN, 7);
    wrReg(4'd0, 8'h00);
    expCal = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0};
    expSel = '{5'd0, 5'd5, 5'd7, 5'd0, 5'd5, 5'd9, 5'd7};
    for (int i = 0; i < 7; i++) begin
      chk(logCal[i] == expCal[i] && logSel[i] == expSel[i], "R7 R12 step sequence", logSel[i], expSel[i]);
    end

    // hardware set beats software clear
    repeat (6) @(negedge clk);
    wrReg(4'd4, 8'd3); wrReg(4'd5, 8'h1F); wrReg(4'd6, 8'h1F); wrReg(4'd3, 8'd2);
    wrReg(4'd1, 8'hFF);
    wrReg(4'd0, 8'h01);
    waitEoc(ok);
    collideSel = 5'd3; collideArm = 1;
    for (int i = 0; i < 3000 && collideArm; i++) @(negedge clk);
    rdReg(4'd1, d);
    chk(d[1] == 1'b1, "R11 set wins over clear", d[1], 1);

    // idle request halts, re-enable waits again
    idleReq = 1'b1;
    @(negedge clk); idleReq = 1'b0;
    @(negedge clk);
    chk(convReq == 1'b0, "R9 idle stops requests", convReq, 0);
    rdReg(4'd0, d); chk(d[0] == 1'b0, "R9 idle clears run bit", d[0], 0);
    highs = 0;
    for (int i = 0; i < 50; i++) begin @(negedge clk); if (convReq) highs++; end
    chk(highs == 0, "R9 stays halted", highs, 0);
    logN = 0;
    wrReg(4'd0, 8'h01);
    enCyc = cyc;
    waitLog(1, ok);
    chk(ok && firstReqCyc - enCyc >= ACT, "R6 activation after re-enable", firstReqCyc - enCyc, ACT);

    // warm reset
    wrReg(4'd2, 8'h0F);
    waitEoc(ok);
    warmRst = 1'b1;
    @(negedge clk); warmRst = 1'b0;
    @(negedge clk);
    chk(convReq == 1'b0 && irq == 1'b0, "R9 warm reset halts", {convReq, irq}, 0);
    rdReg(4'd0, d); chk(d == 8'h00, "R10 warm reset run bit", d, 0);
    rdReg(4'd1, d); chk(d == 8'h00, "R10 warm reset flags", d, 0);
    rdReg(4'd2, d); chk(d == 8'h00, "R10 warm reset masks", d, 0);

    // software disable while running
    logN = 0;
    wrReg(4'd0, 8'h01);
    waitLog(1, ok);
    wrReg(4'd0, 8'h00);
    @(negedge clk);
    chk(convReq == 1'b0, "R9 software disable halts", convReq, 0);

    finishRun();
  end
endmodule